// File: doc/BRIEF.md
# PCI Delayed-Completion Memory Target

This block is a conventional-PCI target that never stalls the bus while it waits for slow storage. When an initiator addresses it with a memory read or a memory write, the block answers the first data phase with a retry (STOP without TRDY). At the same moment it records the full request in a single slot. While the initiator is away, the block runs the access on a simple request/acknowledge memory port. The initiator then repeats the same request, and that retry is finished with the buffered result.

Every transfer is a single data phase. A completion therefore drives TRDY and STOP together, which is a disconnect with data. Address decoding uses medium DEVSEL timing. If a stored completion is never collected, a discard timer frees the slot. The block has no configuration space, no parity, no 64-bit extension and no dual address cycles.

Top module: `pci_dly_target`

## Requirements
- R1: The block claims an address phase only when the command is memory read (4'b0110) or memory write (4'b0111) and address bits [31:WIN_BITS] equal the same bits of BASE_ADDR. Any other command or address never asserts DEVSEL, TRDY or STOP.
- R2: DEVSEL goes low on the second rising edge after the edge at which FRAME is first sampled low with a claimed address.
- R3: When the slot is empty, a claimed request with at least one byte enabled is answered with STOP low and TRDY high. The command, the address, the active-low byte enables and, for a write, the AD data are stored in the slot.
- R4: A stored request raises mem_req, and mem_req stays high with stable outputs until mem_ack. mem_we is command bit 0 (1 means write). mem_addr is address bits [WIN_BITS-1:2]. mem_be is the bitwise inverse of the stored byte enables, so a partial write changes only the enabled bytes.
- R5: A retry whose command, address and byte enables match the slot (and, for a write, whose data matches) is completed once the backend result is stored. TRDY and STOP go low together. A read drives the stored word on ad_out with ad_oe high. The slot is then freed.
- R6: A matching retry that is judged before the backend result has been stored gets STOP without TRDY. This includes a retry judged on the same edge at which mem_ack is accepted.
- R7: While the slot is occupied, a different request gets STOP without TRDY and is not recorded. After the slot is freed, its next attempt is captured as a new request.
- R8: A write retry whose data differs from the stored write data is not a match. It is retried, and the differing data is never written.
- R9: A data phase with all byte enables high completes on the first attempt with TRDY and STOP. It starts no backend access, changes no memory, and a read returns zero.
- R10: A stored completion that is not collected within DISCARD_CLKS clocks is dropped. The next identical request is captured again and issues a new backend access.
- R11: After reset, DEVSEL, TRDY and STOP are high, ad_oe is low, mem_req is low and the slot is empty.
- R12: Each answer (DEVSEL with STOP, and with TRDY where given) lasts exactly one clock. On the following clock all target outputs are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data bus as seen by the target |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Output enable for ad_out |
| mem_req | output | 1 | Backend access request |
| mem_we | output | 1 | Backend write select |
| mem_addr | output | WIN_BITS-2 | Backend word address |
| mem_wdata | output | 32 | Backend write data |
| mem_be | output | 4 | Backend byte enables, active high |
| mem_ack | input | 1 | Backend acknowledge, one-clock pulse |
| mem_rdata | input | 32 | Backend read data, valid with mem_ack |

## Verification
The delicate overlap is a backend acknowledgment accepted on the same clock edge at which a retry of the stored request is judged. The bench sets the latency of its memory model so that mem_ack is consumed exactly on the decision edge of the very next retry. It then expects STOP without TRDY for that retry and the stored data on the one after it. The bench repeats the sequence with a latency one clock shorter, where the same first retry must already be completed. A second overlap, a completion being collected on the edge at which the discard timer expires, is resolved in favour of the collection by the slot logic.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int AD_W = 32;
  localparam int BE_W = AD_W / 8;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_RESPOND,
    ST_RELEASE
  } bus_state_t;

  typedef struct packed {
    logic [3:0]      cmd;
    logic [AD_W-1:0] addr;
    logic [BE_W-1:0] be_n;
    logic [AD_W-1:0] wdata;
  } dly_req_t;
endpackage

// File: rtl/pdt_addr_decode.sv
module pdt_addr_decode
  import pdt_pkg::*;
#(
  parameter logic [AD_W-1:0] BASE_ADDR = 32'h8000_0000,
  parameter int              WIN_BITS  = 12
) (
  input  logic [AD_W-1:WIN_BITS] addr_hi,
  input  logic [3:0]             cmd,
  output logic                   claim
);
  logic cmd_ok;
  logic win_ok;

  assign cmd_ok = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  assign win_ok = (addr_hi == BASE_ADDR[AD_W-1:WIN_BITS]);
  assign claim  = cmd_ok && win_ok;
endmodule

// File: rtl/pdt_slot.sv
module pdt_slot
  import pdt_pkg::*;
#(
  parameter int WIN_BITS     = 12,
  parameter int WORD_W       = 10,
  parameter int DISCARD_CLKS = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  dly_req_t          probe,
  input  logic              capture,
  input  logic              deliver,
  output logic              occupied,
  output logic              ready,
  output logic              same,
  output logic [AD_W-1:0]   result,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [AD_W-1:0]   mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ack,
  input  logic [AD_W-1:0]   mem_rdata
);
  localparam int TMR_W = $clog2(DISCARD_CLKS + 1);

  dly_req_t         held;
  logic             pending;
  logic [TMR_W-1:0] timer;
  logic             expire;

  // a write additionally needs identical data to count as the same request
  assign same = (held.cmd == probe.cmd) && (held.addr == probe.addr) &&
                (held.be_n == probe.be_n) &&
                (!held.cmd[0] || (held.wdata == probe.wdata));

  assign expire = ready && (timer == TMR_W'(DISCARD_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      occupied <= 1'b0;
      pending  <= 1'b0;
      ready    <= 1'b0;
      timer    <= '0;
      result   <= '0;
    end else begin
      if (capture && !occupied) begin
        held     <= probe;
        occupied <= 1'b1;
        pending  <= 1'b1;
        ready    <= 1'b0;
        timer    <= '0;
      end else if (pending && mem_ack) begin
        pending <= 1'b0;
        ready   <= 1'b1;
        result  <= held.cmd[0] ? '0 : mem_rdata;
      end else if (deliver || expire) begin
        occupied <= 1'b0;
        ready    <= 1'b0;
      end else if (ready) begin
        timer <= timer + 1'b1;
      end
    end
  end

  assign mem_req   = pending;
  assign mem_we    = held.cmd[0];
  assign mem_addr  = held.addr[WIN_BITS-1:2];
  assign mem_wdata = held.wdata;
  assign mem_be    = ~held.be_n;
endmodule

// File: rtl/pci_dly_target.sv
module pci_dly_target
  import pdt_pkg::*;
#(
  parameter logic [AD_W-1:0] BASE_ADDR    = 32'h8000_0000,
  parameter int              WIN_BITS     = 12,
  parameter int              DISCARD_CLKS = 32768
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  input  logic [AD_W-1:0]       ad_in,
  input  logic [BE_W-1:0]       cbe_n,
  output logic                  devsel_n,
  output logic                  trdy_n,
  output logic                  stop_n,
  output logic [AD_W-1:0]       ad_out,
  output logic                  ad_oe,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [WIN_BITS-3:0]   mem_addr,
  output logic [AD_W-1:0]       mem_wdata,
  output logic [BE_W-1:0]       mem_be,
  input  logic                  mem_ack,
  input  logic [AD_W-1:0]       mem_rdata
);
  localparam int WORD_W = WIN_BITS - 2;

  bus_state_t      state;
  logic            frame_q;
  logic [AD_W-1:0] addr_q;
  logic [3:0]      cmd_q;
  logic            claim;
  logic            addr_phase;
  logic            answer;
  logic            noop;
  logic            take;
  logic            grab;
  dly_req_t        probe;
  logic            slot_occ;
  logic            slot_ready;
  logic            slot_same;
  logic [AD_W-1:0] slot_result;

  pdt_addr_decode #(
    .BASE_ADDR(BASE_ADDR),
    .WIN_BITS (WIN_BITS)
  ) decode_i (
    .addr_hi(ad_in[AD_W-1:WIN_BITS]),
    .cmd    (cbe_n),
    .claim  (claim)
  );

  assign addr_phase  = (state == ST_IDLE) && frame_q && !frame_n;
  assign answer      = (state == ST_RESPOND) && !irdy_n;
  assign noop        = &cbe_n;
  assign take        = answer && !noop && slot_ready && slot_same;
  assign grab        = answer && !noop && !slot_occ;

  assign probe.cmd   = cmd_q;
  assign probe.addr  = addr_q;
  assign probe.be_n  = cbe_n;
  assign probe.wdata = cmd_q[0] ? ad_in : '0;

  pdt_slot #(
    .WIN_BITS    (WIN_BITS),
    .WORD_W      (WORD_W),
    .DISCARD_CLKS(DISCARD_CLKS)
  ) slot_i (
    .clk      (clk),
    .rst      (rst),
    .probe    (probe),
    .capture  (grab),
    .deliver  (take),
    .occupied (slot_occ),
    .ready    (slot_ready),
    .same     (slot_same),
    .result   (slot_result),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_be   (mem_be),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      frame_q  <= 1'b1;
      addr_q   <= '0;
      cmd_q    <= '0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ad_out   <= '0;
      ad_oe    <= 1'b0;
    end else begin
      frame_q <= frame_n;
      unique case (state)
        ST_IDLE: begin
          if (addr_phase && claim) begin
            addr_q <= ad_in;
            cmd_q  <= cbe_n;
            state  <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          devsel_n <= 1'b0;
          state    <= ST_RESPOND;
        end
        ST_RESPOND: begin
          if (answer) begin
            stop_n <= 1'b0;
            if (noop || take) begin
              trdy_n <= 1'b0;
              ad_oe  <= !cmd_q[0];
              ad_out <= (noop || cmd_q[0]) ? '0 : slot_result;
            end
            state <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          devsel_n <= 1'b1;
          trdy_n   <= 1'b1;
          stop_n   <= 1'b1;
          ad_oe    <= 1'b0;
          ad_out   <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker (
  input logic        clk,
  input logic        rst,
  input logic        frame_n,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        stop_n,
  input logic        ad_oe,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        mem_ack
);
  // R12
  stop_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |=> stop_n);

  // R5
  trdy_paired_chk: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> (!stop_n && !devsel_n));

  // R5
  ad_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !trdy_n);

  // R2
  devsel_medium_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> ($past(frame_n, 2) == 1'b0));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (devsel_n && trdy_n && stop_n && !ad_oe && !mem_req));
endmodule

bind pci_dly_target pdt_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .frame_n  (frame_n),
  .devsel_n (devsel_n),
  .trdy_n   (trdy_n),
  .stop_n   (stop_n),
  .ad_oe    (ad_oe),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack)
);

// File: tb/pci_dly_target_tb_top.sv
module pci_dly_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_BITS   = 12;
  localparam int DISCARD    = 40;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [3:0]  be_n;
    logic [31:0] wdata;
    logic        claim;
    logic [31:0] rexp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    {4'h7, 32'h8000_0010, 4'h0, 32'hA5A5_1234, 1'b1, 32'h0},
    {4'h6, 32'h8000_0010, 4'h0, 32'h0,         1'b1, 32'hA5A5_1234},
    {4'h7, 32'h8000_0010, 4'hC, 32'hFFFF_BEEF, 1'b1, 32'h0},
    {4'h6, 32'h8000_0010, 4'h0, 32'h0,         1'b1, 32'hA5A5_BEEF},
    {4'h6, 32'h8000_0010, 4'hE, 32'h0,         1'b1, 32'hA5A5_BEEF},
    {4'h6, 32'h9000_0010, 4'h0, 32'h0,         1'b0, 32'h0},
    {4'h2, 32'h8000_0010, 4'h0, 32'h0,         1'b0, 32'h0},
    {4'hF, 32'h8000_0010, 4'h0, 32'h0,         1'b0, 32'h0},
    {4'h7, 32'h8000_0FFC, 4'h0, 32'h0BAD_F00D, 1'b1, 32'h0},
    {4'h6, 32'h8000_0FFC, 4'h0, 32'h0,         1'b1, 32'h0BAD_F00D}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        devsel_n, trdy_n, stop_n, ad_oe;
  logic [31:0] ad_out;
  logic        mem_req, mem_we;
  logic [WIN_BITS-3:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int lat = 3;
  int wait_cnt = 0;
  int req_count = 0;
  logic [31:0] mem [0:(1<<(WIN_BITS-2))-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_dly_target #(
    .BASE_ADDR   (32'h8000_0000),
    .WIN_BITS    (WIN_BITS),
    .DISCARD_CLKS(DISCARD)
  ) dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // backend memory model, updated away from the active edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= lat - 1) begin
        mem_ack   <= 1'b1;
        wait_cnt  <= 0;
        req_count <= req_count + 1;
        mem_rdata <= mem[mem_addr];
        if (mem_we)
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic bus_txn(input logic [3:0] cmd, input logic [31:0] addr,
                         input logic [3:0] be_n, input logic [31:0] wdata,
                         output logic claimed, output logic done,
                         output logic [31:0] rdata, output logic oe,
                         output int dsel_at, output logic released);
    claimed = 1'b0; done = 1'b0; rdata = '0; oe = 1'b0; dsel_at = -1;
    @(negedge clk);
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    if (!devsel_n) dsel_at = 1;
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = wdata; cbe_n = be_n;
    for (int k = 2; k < 8; k++) begin
      @(negedge clk);
      if (!devsel_n && dsel_at < 0) dsel_at = k;
      if (!stop_n || !trdy_n) begin
        claimed = 1'b1; done = !trdy_n; rdata = ad_out; oe = ad_oe;
        break;
      end
    end
    @(negedge clk);
    released = devsel_n && trdy_n && stop_n && !ad_oe;
    irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
  endtask

  // full delayed sequence: first attempt must retry, retries until completion
  task automatic delayed_access(input string req, input logic [3:0] cmd, input logic [31:0] addr,
                                input logic [3:0] be_n, input logic [31:0] wdata,
                                input logic [31:0] rexp, input logic chk_data);
    logic c, d, o, rl; logic [31:0] r; int ds;
    bus_txn(cmd, addr, be_n, wdata, c, d, r, o, ds, rl);
    check({req, " R3 first attempt retried"}, {31'd0, c && !d}, 32'd1);
    check({req, " R2 devsel delay"}, ds, 32'd2);
    for (int t = 0; t < 10; t++) begin
      repeat (lat + 2) @(negedge clk);
      bus_txn(cmd, addr, be_n, wdata, c, d, r, o, ds, rl);
      if (d) break;
    end
    check({req, " R5 retry completed"}, {31'd0, d}, 32'd1);
    check({req, " R12 released"}, {31'd0, rl}, 32'd1);
    if (chk_data) begin
      check({req, " R5 R4 read data"}, r, rexp);
      check({req, " R5 ad_oe on read"}, {31'd0, o}, 32'd1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic c, d, o, rl; logic [31:0] r; int ds; int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 idle outputs", {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
    check("R11 no backend request", {31'd0, mem_req}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].claim)
        delayed_access($sformatf("vec%0d", i), VECS[i].cmd, VECS[i].addr, VECS[i].be_n,
                       VECS[i].wdata, VECS[i].rexp, !VECS[i].cmd[0]);
      else begin
        bus_txn(VECS[i].cmd, VECS[i].addr, VECS[i].be_n, VECS[i].wdata, c, d, r, o, ds, rl);
        check($sformatf("vec%0d R1 not claimed", i), {31'd0, c}, 32'd0);
        check($sformatf("vec%0d R1 no devsel", i), ds, -32'sd1);
      end
    end

    // R9 no-op data phases
    c0 = req_count;
    bus_txn(4'h7, 32'h8000_0010, 4'hF, 32'hDEAD_DEAD, c, d, r, o, ds, rl);
    check("R9 noop write done on first attempt", {31'd0, d}, 32'd1);
    bus_txn(4'h6, 32'h8000_0010, 4'hF, 32'h0, c, d, r, o, ds, rl);
    check("R9 noop read done, zero data", {31'd0, d} | r, 32'd1);
    repeat (10) @(negedge clk);
    check("R9 no backend access", req_count - c0, 32'd0);
    delayed_access("R9 memory unchanged", 4'h6, 32'h8000_0010, 4'h0, 32'h0, 32'hA5A5_BEEF, 1'b1);

    // R7 busy slot
    lat = 30;
    bus_txn(4'h7, 32'h8000_0020, 4'h0, 32'h1111_1111, c, d, r, o, ds, rl);
    check("R7 A captured with retry", {31'd0, c && !d}, 32'd1);
    bus_txn(4'h7, 32'h8000_0024, 4'h0, 32'h2222_2222, c, d, r, o, ds, rl);
    check("R7 B retried while busy", {31'd0, c && !d}, 32'd1);
    repeat (45) @(negedge clk);
    bus_txn(4'h7, 32'h8000_0020, 4'h0, 32'h1111_1111, c, d, r, o, ds, rl);
    check("R7 A completes", {31'd0, d}, 32'd1);
    bus_txn(4'h7, 32'h8000_0024, 4'h0, 32'h2222_2222, c, d, r, o, ds, rl);
    check("R7 B was not recorded", {31'd0, c && !d}, 32'd1);
    repeat (45) @(negedge clk);
    bus_txn(4'h7, 32'h8000_0024, 4'h0, 32'h2222_2222, c, d, r, o, ds, rl);
    check("R7 B completes after capture", {31'd0, d}, 32'd1);
    lat = 3;

    // R8 write data mismatch
    bus_txn(4'h7, 32'h8000_0030, 4'h0, 32'h3333_3333, c, d, r, o, ds, rl);
    repeat (10) @(negedge clk);
    bus_txn(4'h7, 32'h8000_0030, 4'h0, 32'h4444_4444, c, d, r, o, ds, rl);
    check("R8 differing data retried", {31'd0, c && !d}, 32'd1);
    bus_txn(4'h7, 32'h8000_0030, 4'h0, 32'h3333_3333, c, d, r, o, ds, rl);
    check("R8 matching data completes", {31'd0, d}, 32'd1);
    delayed_access("R8 stored value", 4'h6, 32'h8000_0030, 4'h0, 32'h0, 32'h3333_3333, 1'b1);

    // R10 discard timer
    bus_txn(4'h6, 32'h8000_0030, 4'h0, 32'h0, c, d, r, o, ds, rl);
    repeat (DISCARD + 40) @(negedge clk);
    c0 = req_count;
    bus_txn(4'h6, 32'h8000_0030, 4'h0, 32'h0, c, d, r, o, ds, rl);
    check("R10 dropped completion not delivered", {31'd0, c && !d}, 32'd1);
    repeat (10) @(negedge clk);
    check("R10 backend access reissued", req_count - c0, 32'd1);
    bus_txn(4'h6, 32'h8000_0030, 4'h0, 32'h0, c, d, r, o, ds, rl);
    check("R10 recaptured read data", r, 32'h3333_3333);

    // R6 ack accepted on the decision edge of the retry
    lat = 5;
    bus_txn(4'h6, 32'h8000_0030, 4'h0, 32'h0, c, d, r, o, ds, rl);
    bus_txn(4'h6, 32'h8000_0030, 4'h0, 32'h0, c, d, r, o, ds, rl);
    check("R6 same-edge ack still retried", {31'd0, c && !d}, 32'd1);
    bus_txn(4'h6, 32'h8000_0030, 4'h0, 32'h0, c, d, r, o, ds, rl);
    check("R6 next retry delivers", r, 32'h3333_3333);
    lat = 4;
    bus_txn(4'h6, 32'h8000_0024, 4'h0, 32'h0, c, d, r, o, ds, rl);
    bus_txn(4'h6, 32'h8000_0024, 4'h0, 32'h0, c, d, r, o, ds, rl);
    check("R6 one clock earlier ack delivers", {31'd0, d}, 32'd1);
    check("R6 R7 data of B", r, 32'h2222_2222);

    summary();
    $finish;
  end
endmodule